// File: doc/BRIEF.md
# Synchronous Serial Master Receiver

This block receives one frame of serial data while driving the serial clock itself. A baud-tick pulse from an outside rate generator steps a 2-bit phase counter, so four ticks make one bit period and one period of the serial clock. Within each period the data input is captured into a holding bit on one tick and moved into the shift register on the next. Software starts a frame by setting the enable bit. Reception begins at the next shift point, and the serial clock leaves its idle level only from then on.

When the last bit has been shifted in, the assembled word is copied into the receive buffer. The hardware clears the enable bit in the same cycle. Completion becomes visible on the receive-complete flag at the next instruction-boundary strobe. If the previous word was still unread, an overrun is flagged and the buffer is overwritten. A buffer-read strobe counts as software reading the buffer.

Top module: `sync_rx_master`

## Requirements
- R1: After reset, the serial clock output is high, the enable bit is 0, the buffer is 0 and both flags are 0.
- R2: The phase counter advances by one, modulo 4, on every baud tick and holds otherwise. While a frame is active, the serial clock is low when the phase is 0 or 1 and high when it is 2 or 3.
- R3: While no frame is active, the serial clock stays high, including while the enable bit is set. A frame starts on the first baud tick that arrives with the phase at 3 and the enable bit at 1, and the serial clock falls on the cycle after that tick.
- R4: The data input is captured only on a baud tick with the phase at 2. Its value at any other time has no effect on the received word.
- R5: A frame is 8 shifts, one on each phase-3 baud tick after the start. The first received bit lands in bit 0 of the buffer, which is loaded in the cycle after the eighth shift.
- R6: The enable bit is cleared by hardware in the cycle the buffer is loaded. The serial clock then returns high until the next start.
- R7: The receive-complete flag rises in the cycle after the first instruction-boundary strobe that follows a buffer load, and never earlier.
- R8: When the buffer is loaded while the previous word is unread, the overrun flag is set and the buffer takes the new word.
- R9: A buffer-read strobe clears the receive-complete and overrun flags in the next cycle, unless the same cycle also raises the receive-complete flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick_i | input | 1 | One-cycle pulse from the rate generator |
| rx_en_set_i | input | 1 | Software write that sets the enable bit |
| sdi_i | input | 1 | Serial data input |
| buf_rd_i | input | 1 | Strobe marking a read of the receive buffer |
| instr_stb_i | input | 1 | Instruction-boundary strobe |
| sclk_o | output | 1 | Serial clock output, idle high |
| rx_en_o | output | 1 | Current state of the enable bit |
| rx_buf_o | output | 8 | Receive buffer |
| rx_done_o | output | 1 | Receive-complete flag |
| rx_ovr_o | output | 1 | Overrun flag |

## Verification
A phase counter that is out of step shows on the serial clock within one baud tick of a frame starting. It also samples data in the low half of the clock, where the bench drives inverted data, so the received word comes out wrong at the next buffer load. A wrong bit count moves the buffer load and the clearing of the enable bit by at least one bit period. A lost unread or pending state shows on the overrun flag at the next load, or on the completion flag at the next instruction strobe. The bench compares every output against a behavioural model on every cycle, so each of these errors is reported in the cycle where it first appears.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  typedef logic [1:0] phase_t;
  localparam phase_t PH_SAMPLE = 2'd2;
  localparam phase_t PH_SHIFT  = 2'd3;
endpackage

// File: rtl/sync_rx_phase.sv
module sync_rx_phase
  import sync_rx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick_i,
  output phase_t phase_o,
  output logic   sample_o,
  output logic   shift_o
);
  phase_t phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (tick_i) phase_d = phase_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign phase_o  = phase_q;
  assign sample_o = tick_i && (phase_q == PH_SAMPLE);
  assign shift_o  = tick_i && (phase_q == PH_SHIFT);

  // R2: phase steps once per tick, holds otherwise
  a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> phase_q == phase_t'($past(phase_q) + 2'd1));
  a_r2_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(phase_q));
endmodule

// File: rtl/sync_rx_shift.sv
module sync_rx_shift #(
  parameter int FRAME_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sample_i,
  input  logic                  shift_i,
  input  logic                  sdi_i,
  input  logic                  en_i,
  output logic                  active_o,
  output logic                  frame_done_o,
  output logic [FRAME_BITS-1:0] frame_data_o
);
  localparam int CNT_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

  logic                  hold_q, hold_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d, sh_next;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic                  act_q, act_d;
  logic                  start, shft, last;

  assign sh_next = {hold_q, sh_q[FRAME_BITS-1:1]};
  assign start   = shift_i && en_i && !act_q;
  assign shft    = shift_i && act_q;
  assign last    = shft && (cnt_q == LAST);

  always_comb begin
    hold_d = hold_q;
    if (sample_i) hold_d = sdi_i;
    sh_d = sh_q;
    if (shft) sh_d = sh_next;
    cnt_d = cnt_q;
    act_d = act_q;
    if (start) begin
      cnt_d = '0;
      act_d = 1'b1;
    end else if (shft) begin
      if (last) begin
        cnt_d = '0;
        act_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      sh_q   <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      act_q  <= act_d;
    end
  end

  assign active_o     = act_q;
  assign frame_done_o = last;
  assign frame_data_o = sh_next;

  // R3: a frame only starts from a shift point with enable set
  a_r3_start_cond: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> $past(shift_i) && $past(en_i));
  // R5: after the last shift the counter wraps and the frame ends
  a_r5_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (cnt_q == '0) && !act_q);
endmodule

// File: rtl/sync_rx_status.sv
module sync_rx_status #(
  parameter int FRAME_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_done_i,
  input  logic [FRAME_BITS-1:0] frame_data_i,
  input  logic                  en_set_i,
  input  logic                  buf_rd_i,
  input  logic                  instr_stb_i,
  output logic                  en_o,
  output logic [FRAME_BITS-1:0] buf_o,
  output logic                  done_o,
  output logic                  ovr_o
);
  logic                  en_q, en_d;
  logic [FRAME_BITS-1:0] buf_q, buf_d;
  logic                  done_q, done_d;
  logic                  ovr_q, ovr_d;
  logic                  unread_q, unread_d;
  logic                  pend_q, pend_d;

  always_comb begin
    en_d = en_q;
    if (en_set_i)          en_d = 1'b1;
    else if (frame_done_i) en_d = 1'b0;

    buf_d = buf_q;
    if (frame_done_i) buf_d = frame_data_i;

    unread_d = unread_q;
    if (frame_done_i)  unread_d = 1'b1;
    else if (buf_rd_i) unread_d = 1'b0;

    ovr_d = ovr_q;
    if (frame_done_i && unread_q && !buf_rd_i) ovr_d = 1'b1;
    else if (buf_rd_i)                         ovr_d = 1'b0;

    pend_d = pend_q;
    if (frame_done_i)               pend_d = 1'b1;
    else if (instr_stb_i && pend_q) pend_d = 1'b0;

    done_d = done_q;
    if (instr_stb_i && pend_q) done_d = 1'b1;
    else if (buf_rd_i)         done_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      buf_q    <= '0;
      done_q   <= 1'b0;
      ovr_q    <= 1'b0;
      unread_q <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      en_q     <= en_d;
      buf_q    <= buf_d;
      done_q   <= done_d;
      ovr_q    <= ovr_d;
      unread_q <= unread_d;
      pend_q   <= pend_d;
    end
  end

  assign en_o   = en_q;
  assign buf_o  = buf_q;
  assign done_o = done_q;
  assign ovr_o  = ovr_q;

  // R6: hardware clears the enable bit at the load
  a_r6_en_clear: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_i && !en_set_i |=> !en_q);
  // R7: completion waits for a strobe
  a_r7_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q && !(instr_stb_i && pend_q) |=> !done_q);
  // R8: an unread buffer overrun is flagged
  a_r8_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_i && unread_q && !buf_rd_i |=> ovr_q);
  // R9: a read clears the overrun flag
  a_r9_rd_clears: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd_i |=> !ovr_q);
endmodule

// File: rtl/sync_rx_master.sv
module sync_rx_master
  import sync_rx_pkg::*;
#(
  parameter int FRAME_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  baud_tick_i,
  input  logic                  rx_en_set_i,
  input  logic                  sdi_i,
  input  logic                  buf_rd_i,
  input  logic                  instr_stb_i,
  output logic                  sclk_o,
  output logic                  rx_en_o,
  output logic [FRAME_BITS-1:0] rx_buf_o,
  output logic                  rx_done_o,
  output logic                  rx_ovr_o
);
  logic [1:0]            rst_sync_q;
  logic                  rst_n_s;
  phase_t                phase;
  logic                  sample_stb, shift_stb;
  logic                  active, frame_done;
  logic [FRAME_BITS-1:0] frame_data;
  logic                  en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  sync_rx_phase u_phase (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .tick_i   (baud_tick_i),
    .phase_o  (phase),
    .sample_o (sample_stb),
    .shift_o  (shift_stb)
  );

  sync_rx_shift #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .sample_i     (sample_stb),
    .shift_i      (shift_stb),
    .sdi_i        (sdi_i),
    .en_i         (en),
    .active_o     (active),
    .frame_done_o (frame_done),
    .frame_data_o (frame_data)
  );

  sync_rx_status #(.FRAME_BITS(FRAME_BITS)) u_status (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .frame_done_i (frame_done),
    .frame_data_i (frame_data),
    .en_set_i     (rx_en_set_i),
    .buf_rd_i     (buf_rd_i),
    .instr_stb_i  (instr_stb_i),
    .en_o         (en),
    .buf_o        (rx_buf_o),
    .done_o       (rx_done_o),
    .ovr_o        (rx_ovr_o)
  );

  assign sclk_o  = active ? phase[1] : 1'b1;
  assign rx_en_o = en;

  // R3: serial clock idles high outside a frame
  a_r3_idle_high: assert property (@(posedge clk) disable iff (!rst_n_s)
    !active |-> sclk_o);
  // R6: enable clear and frame end coincide with the load
  a_r6_load_ends: assert property (@(posedge clk) disable iff (!rst_n_s)
    frame_done && !rx_en_set_i |=> !rx_en_o && sclk_o);
endmodule

// File: tb/sync_rx_master_bench.sv
`timescale 1ns/1ps
module sync_rx_master_bench;
  localparam int FB   = 8;
  localparam int MASK = (1 << FB) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick = 1'b0, en_set = 1'b0, sdi = 1'b0, buf_rd = 1'b0, instr_stb = 1'b0;
  logic sclk, rx_en, rx_done, rx_ovr;
  logic [FB-1:0] rx_buf;

  int checks = 0, errors = 0;
  bit go = 1'b0;
  int tick_pct = 50;
  int tx_word = 0;

  // behavioural model state
  int m_ph, m_hold, m_sh, m_cnt, m_buf;
  bit m_act, m_en, m_done, m_ovr, m_unread, m_pend;

  always #2.5 clk = ~clk;

  sync_rx_master #(.FRAME_BITS(FB)) u_sync_rx_master (
    .clk(clk), .rst_n(rst_n), .baud_tick_i(baud_tick), .rx_en_set_i(en_set),
    .sdi_i(sdi), .buf_rd_i(buf_rd), .instr_stb_i(instr_stb),
    .sclk_o(sclk), .rx_en_o(rx_en), .rx_buf_o(rx_buf),
    .rx_done_o(rx_done), .rx_ovr_o(rx_ovr)
  );

  function automatic bit m_sclk();
    return m_act ? (m_ph >= 2) : 1'b1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_hold = 0; m_sh = 0; m_cnt = 0; m_buf = 0;
      m_act = 0; m_en = 0; m_done = 0; m_ovr = 0; m_unread = 0; m_pend = 0;
    end else begin
      bit xfer;
      xfer = 1'b0;
      if (buf_rd) begin m_unread = 0; m_done = 0; m_ovr = 0; end
      if (instr_stb && m_pend) begin m_done = 1; m_pend = 0; end
      if (baud_tick) begin
        if (m_ph == 3) begin
          if (m_act) begin
            m_sh = ((m_sh >> 1) | (m_hold << (FB - 1))) & MASK;
            m_cnt++;
            if (m_cnt == FB) xfer = 1'b1;
          end else if (m_en) begin
            m_act = 1; m_cnt = 0;
          end
        end
        if (m_ph == 2) m_hold = sdi;
        m_ph = (m_ph + 1) % 4;
      end
      if (xfer) begin
        m_buf = m_sh;
        if (m_unread) m_ovr = 1;
        m_unread = 1; m_pend = 1; m_act = 0; m_en = 0; m_cnt = 0;
      end
      if (en_set) m_en = 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rst_n && go) begin
      check(sclk == m_sclk(), "R2 R3 sclk", sclk, m_sclk());
      check(rx_en == m_en, "R6 enable", rx_en, m_en);
      check(rx_buf == m_buf[FB-1:0], "R5 R4 buffer", rx_buf, m_buf);
      check(rx_done == m_done, "R7 R9 done", rx_done, m_done);
      check(rx_ovr == m_ovr, "R8 R9 overrun", rx_ovr, m_ovr);
    end
  end

  // free-running stimulus: ticks, strobes, and a transmitter that drives the
  // true bit while the clock is high and its inverse while it is low (R4)
  always begin
    @(negedge clk); #1;
    if (go) begin
      baud_tick <= (($urandom % 100) < tick_pct);
      instr_stb <= (($urandom % 12) == 0);
      sdi <= m_sclk() ? tx_word[m_cnt % FB] : ~tx_word[m_cnt % FB];
    end
  end

  task automatic pulse_en();
    @(negedge clk); #1; en_set <= 1'b1;
    @(negedge clk); #1; en_set <= 1'b0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); #1; buf_rd <= 1'b1;
    @(negedge clk); #1; buf_rd <= 1'b0;
  endtask

  task automatic run_frame(input int word);
    tx_word = word;
    pulse_en();
    // R3: clock stays high while enabled but not yet started
    @(negedge clk);
    if (!m_act) check(sclk == 1'b1, "R3 idle while enabled", sclk, 1);
    while (m_en) @(negedge clk);
    repeat (40) @(negedge clk);
    check(rx_buf == word[FB-1:0], "R5 R4 frame word", rx_buf, word);
    check(rx_en == 1'b0, "R6 enable cleared", rx_en, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(sclk == 1'b1 && rx_en == 1'b0, "R1 sclk/enable", {sclk, rx_en}, 2);
    check(rx_buf == '0 && !rx_done && !rx_ovr, "R1 buffer/flags", {rx_buf, rx_done, rx_ovr}, 0);
    #1 rst_n = 1'b1;
    repeat (5) @(negedge clk);
    go = 1'b1;

    run_frame(8'hA5);
    check(rx_done == 1'b1, "R7 done after strobe", rx_done, 1);
    check(rx_ovr == 1'b0, "R8 no overrun first", rx_ovr, 0);
    pulse_rd();
    @(negedge clk);
    check(!rx_done && !rx_ovr, "R9 read clears", {rx_done, rx_ovr}, 0);

    tick_pct = 100;
    run_frame(8'h3C);
    run_frame(8'hC1);                       // unread: overrun
    check(rx_ovr == 1'b1, "R8 overrun set", rx_ovr, 1);
    pulse_rd();
    @(negedge clk);
    check(!rx_done && !rx_ovr, "R9 read clears overrun", {rx_done, rx_ovr}, 0);

    tick_pct = 30;
    for (int i = 0; i < 4; i++) begin
      run_frame(($urandom % 256));
      if (i % 2 == 0) pulse_rd();
    end
    tick_pct = 70;
    run_frame(8'h00);
    run_frame(8'hFF);

    go = 1'b0;
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule